// File: doc/BRIEF.md
# Vectorised Conditional Branch Step Evaluator

This unit resolves one element step of a conditional branch that runs inside a vector loop. The issue logic presents decoded fields once per element: a 5-bit options field, the selected condition bit, the counter value, the current instruction address, a 14-bit word displacement or the link register value, mode flags and the loop state, which is the element index and an incoming end-of-loop flag. With a single-cycle `inValid` strobe the unit registers the result one clock later. The result holds the updated counter, the next instruction address, a taken strobe, a link-register write, a vector-length write and the new end-of-loop flag.

Vector semantics sit on top of the classic counter and condition tests. A step can shorten the vector length when the combined test result matches a chosen sense. In all-elements mode a branch is allowed only once the loop is ending, and a failing test leaves the loop early. A zeroing flag replaces the condition bit with a fixed substitute, and a flag can allow the link register to be written even when the branch is not taken. A second variant branches to the link register and uses only the plain tests.

Top module: `vec_branch_step`

## Requirements
- R1: The options field `opts[4:0]` is numbered MSB-first, so option bit k is `opts[4-k]`. When option bit 2 (`opts[2]`) is 0, `ctrNext` is `ctrIn - 1` with 64-bit wrap. When it is 1, `ctrNext` is `ctrIn`.
- R2: The counter test passes when `opts[2]` is 1, or when (post-decrement counter nonzero) XOR `opts[1]` is 1. With `mode64` = 0 only the low 32 bits are checked for zero. With `mode64` = 1 all 64 bits are checked.
- R3: The condition test passes when `opts[4]` is 1, or when the tested bit equals `opts[3]`. The tested bit is `snz` when `zeroing` is 1, and `condBit` otherwise.
- R4: With `toLr` = 0 and `vlSet` = 1, if (counter test AND condition test) equals `vsb`, then `vlWrEn` pulses and end-of-loop is set. `vlValue` is `srcStep + 1` (7-bit wrap) when `vlInc` is 1 and `srcStep` otherwise, and it is registered on every valid step.
- R5: With `toLr` = 0 and `allMode` = 1, no branch is taken unless end-of-loop is already set after the R4 step. If either test fails, end-of-loop is set and no branch is taken.
- R6: A branch is taken when both tests pass and R5 does not block it. With `toLr` = 0, a taken branch sets end-of-loop. In every other case the result `endLoop` equals `endLoopIn`, updated as R4 and R5 say.
- R7: The taken target is `cia` plus the sign-extended displacement shifted left by 2. With `absMode` = 1 it is the shifted, sign-extended displacement alone. When the branch is not taken, `nextAddr` is `cia + 4`.
- R8: With `mode64` = 0, bits 63..32 of `nextAddr` and `lrValue` are 0.
- R9: `lrWrEn` pulses when `link` = 1 and (`lrU` = 1 or the branch is taken). `lrValue` is `cia + 4` and is registered on every valid step.
- R10: With `toLr` = 1, the target is `lrIn` with bits 1..0 cleared. `vlWrEn` stays 0 and `endLoop` equals `endLoopIn`, whatever `vlSet`, `allMode` and the outcome are.
- R11: All results appear one clock after `inValid`. `outValid`, `branchTaken`, `lrWrEn` and `vlWrEn` are 0 in cycles that follow no valid input. All other outputs hold their values. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Step inputs are valid this cycle |
| opts | input | 5 | Branch options field, option bit k at opts[4-k] |
| condBit | input | 1 | Selected condition-register bit |
| snz | input | 1 | Substitute tested bit used under zeroing |
| zeroing | input | 1 | Use snz in place of condBit |
| ctrIn | input | 64 | Counter register value |
| cia | input | 64 | Current instruction address |
| disp | input | 14 | Word displacement |
| lrIn | input | 64 | Link register value |
| absMode | input | 1 | Target is absolute displacement |
| toLr | input | 1 | Branch-to-link-register variant |
| link | input | 1 | Request link register update |
| mode64 | input | 1 | 64-bit mode |
| vlSet | input | 1 | Enable vector-length truncation |
| vsb | input | 1 | Test sense that triggers truncation |
| vlInc | input | 1 | Truncate to srcStep+1 instead of srcStep |
| allMode | input | 1 | All-elements semantics |
| lrU | input | 1 | Allow link update without a taken branch |
| srcStep | input | 7 | Current element index |
| endLoopIn | input | 1 | End-of-loop flag before this step |
| outValid | output | 1 | Results registered this cycle |
| branchTaken | output | 1 | Branch taken strobe |
| nextAddr | output | 64 | Next instruction address |
| lrWrEn | output | 1 | Link register write strobe |
| lrValue | output | 64 | Link register write value |
| ctrNext | output | 64 | Updated counter |
| vlWrEn | output | 1 | Vector length write strobe |
| vlValue | output | 7 | Vector length write value |
| endLoop | output | 1 | End-of-loop flag after this step |

## Verification
The hardest case to reach is the all-elements step in which the truncation match sets end-of-loop and the branch then goes ahead in the same step. It needs `vlSet`, `allMode`, a passing combined test equal to `vsb` and a clear `endLoopIn`, all at once. Directed steps build it, and the 32-bit zero test, where the upper counter bits are nonzero while the low word decrements to zero, is set up the same way. Random steps then bias the counter toward 0, 1 and 2^32+1 so that both counter-test outcomes show up often, and a model in the bench checks every output on every clock.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  // Option field positions; option bit k sits at opts[4-k].
  localparam int OPT_COND_IGN = 4;
  localparam int OPT_COND_VAL = 3;
  localparam int OPT_CTR_IGN  = 2;
  localparam int OPT_CTR_ZERO = 1;

  typedef struct packed {
    logic takeBranch;
    logic selLr;
    logic selAbs;
    logic lrWrite;
    logic vlWrite;
    logic vlUseInc;
    logic endLoop;
  } strobes_t;
endpackage

// File: rtl/vbs_ctrl.sv
module vbs_ctrl
  import vbs_pkg::*;
(
  input  logic [4:0] opts,
  input  logic       condBit,
  input  logic       snz,
  input  logic       zeroing,
  input  logic       ctrNonZero,
  input  logic       absMode,
  input  logic       toLr,
  input  logic       link,
  input  logic       vlSet,
  input  logic       vsb,
  input  logic       vlInc,
  input  logic       allMode,
  input  logic       lrU,
  input  logic       endLoopIn,
  output logic       decCtr,
  output strobes_t   strobes
);
  logic ctrOk, condOk, bothOk, testBit, loopEnd, tryBranch, vlHit, taken;

  assign decCtr = ~opts[OPT_CTR_IGN];

  always_comb begin
    ctrOk   = opts[OPT_CTR_IGN] | (ctrNonZero ^ opts[OPT_CTR_ZERO]);
    testBit = zeroing ? snz : condBit;
    condOk  = opts[OPT_COND_IGN] | ~(testBit ^ opts[OPT_COND_VAL]);
    bothOk  = ctrOk & condOk;

    loopEnd   = endLoopIn;
    tryBranch = 1'b1;
    vlHit     = 1'b0;
    if (!toLr) begin
      if (vlSet && (bothOk == vsb)) begin
        vlHit   = 1'b1;
        loopEnd = 1'b1;
      end
      if (allMode) begin
        if (!loopEnd) tryBranch = 1'b0;
        if (!bothOk) begin
          loopEnd   = 1'b1;
          tryBranch = 1'b0;
        end
      end
    end
    taken = tryBranch & bothOk;
    if (taken && !toLr) loopEnd = 1'b1;

    strobes            = '0;
    strobes.takeBranch = taken;
    strobes.selLr      = toLr;
    strobes.selAbs     = absMode;
    strobes.lrWrite    = link & (lrU | taken);
    strobes.vlWrite    = vlHit;
    strobes.vlUseInc   = vlInc;
    strobes.endLoop    = loopEnd;
  end
endmodule

// File: rtl/vbs_datapath.sv
module vbs_datapath
  import vbs_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DISP_W   = 14,
  parameter int VL_W     = 7,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              decCtr,
  input  strobes_t          strobes,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] ctrIn,
  input  logic [ADDR_W-1:0] cia,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] lrIn,
  input  logic [VL_W-1:0]   srcStep,
  output logic              ctrNonZero,
  output logic              outValid,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              lrWrEn,
  output logic [ADDR_W-1:0] lrValue,
  output logic [ADDR_W-1:0] ctrNext,
  output logic              vlWrEn,
  output logic [VL_W-1:0]   vlValue,
  output logic              endLoop
);
  localparam int EXT_W = ADDR_W - DISP_W - 2;
  localparam logic [ADDR_W-1:0] ONE        = 1;
  localparam logic [ADDR_W-1:0] INSN_BYTES = 4;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = 3;
  localparam logic [VL_W-1:0]   VL_ONE     = 1;

  logic [ADDR_W-1:0] ctrDec, offset, target, chosen, addrMask;

  assign ctrDec = decCtr ? (ctrIn - ONE) : ctrIn;
  assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};

  generate
    if (ADDR_W > NARROW_W) begin : g_wide
      assign addrMask   = mode64 ? '1 : {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
      assign ctrNonZero = mode64 ? (|ctrDec) : (|ctrDec[NARROW_W-1:0]);
    end else begin : g_narrow
      assign addrMask   = '1;
      assign ctrNonZero = |ctrDec;
    end
  endgenerate

  always_comb begin
    if (strobes.selLr)       target = lrIn & ~ALIGN_MASK;
    else if (strobes.selAbs) target = offset;
    else                     target = cia + offset;
    chosen = strobes.takeBranch ? target : (cia + INSN_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      branchTaken <= 1'b0;
      lrWrEn      <= 1'b0;
      vlWrEn      <= 1'b0;
      nextAddr    <= '0;
      lrValue     <= '0;
      ctrNext     <= '0;
      vlValue     <= '0;
      endLoop     <= 1'b0;
    end else begin
      outValid    <= inValid;
      branchTaken <= inValid & strobes.takeBranch;
      lrWrEn      <= inValid & strobes.lrWrite;
      vlWrEn      <= inValid & strobes.vlWrite;
      if (inValid) begin
        nextAddr <= chosen & addrMask;
        lrValue  <= (cia + INSN_BYTES) & addrMask;
        ctrNext  <= ctrDec;
        vlValue  <= strobes.vlUseInc ? (srcStep + VL_ONE) : srcStep;
        endLoop  <= strobes.endLoop;
      end
    end
  end

  // R11: strobes quiet and data held after an idle cycle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inValid) |-> (!outValid && !branchTaken && !lrWrEn && !vlWrEn));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inValid) |-> ($stable(nextAddr) && $stable(ctrNext) && $stable(endLoop)));
  // R1: counter steps by one only when asked
  a_r1_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid) |-> (ctrNext == ($past(decCtr) ? $past(ctrIn) - ONE : $past(ctrIn))));
  // R4: a vector-length write always ends the loop
  a_r4_vl_ends: assert property (@(posedge clk) disable iff (!rst_n)
    vlWrEn |-> endLoop);
  // R6: a taken vector branch ends the loop
  a_r6_taken_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inValid && !strobes.selLr) && branchTaken) |-> endLoop);
  // R10: link-register target is word aligned
  a_r10_lr_align: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inValid && strobes.selLr) && branchTaken) |-> (nextAddr[1:0] == 2'b00));
  // R8: upper half cleared in 32-bit mode
  a_r8_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid && !mode64) |-> (((nextAddr | lrValue) & ~{{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}}) == '0));
endmodule

// File: rtl/vec_branch_step.sv
module vec_branch_step
  import vbs_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 14,
  parameter int VL_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [4:0]        opts,
  input  logic              condBit,
  input  logic              snz,
  input  logic              zeroing,
  input  logic [ADDR_W-1:0] ctrIn,
  input  logic [ADDR_W-1:0] cia,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] lrIn,
  input  logic              absMode,
  input  logic              toLr,
  input  logic              link,
  input  logic              mode64,
  input  logic              vlSet,
  input  logic              vsb,
  input  logic              vlInc,
  input  logic              allMode,
  input  logic              lrU,
  input  logic [VL_W-1:0]   srcStep,
  input  logic              endLoopIn,
  output logic              outValid,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              lrWrEn,
  output logic [ADDR_W-1:0] lrValue,
  output logic [ADDR_W-1:0] ctrNext,
  output logic              vlWrEn,
  output logic [VL_W-1:0]   vlValue,
  output logic              endLoop
);
  logic     decCtr, ctrNonZero;
  strobes_t strobes;

  vbs_ctrl i_ctrl (
    .opts(opts), .condBit(condBit), .snz(snz), .zeroing(zeroing),
    .ctrNonZero(ctrNonZero), .absMode(absMode), .toLr(toLr), .link(link),
    .vlSet(vlSet), .vsb(vsb), .vlInc(vlInc), .allMode(allMode), .lrU(lrU),
    .endLoopIn(endLoopIn), .decCtr(decCtr), .strobes(strobes)
  );

  vbs_datapath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .VL_W(VL_W)) i_datapath (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .decCtr(decCtr),
    .strobes(strobes), .mode64(mode64), .ctrIn(ctrIn), .cia(cia), .disp(disp),
    .lrIn(lrIn), .srcStep(srcStep), .ctrNonZero(ctrNonZero),
    .outValid(outValid), .branchTaken(branchTaken), .nextAddr(nextAddr),
    .lrWrEn(lrWrEn), .lrValue(lrValue), .ctrNext(ctrNext), .vlWrEn(vlWrEn),
    .vlValue(vlValue), .endLoop(endLoop)
  );
endmodule

// File: tb/test_vec_branch_step.sv
module test_vec_branch_step;
  typedef struct packed {
    logic [4:0]  opts;
    logic        condBit, snz, zeroing;
    logic [63:0] ctr, cia, lr;
    logic [13:0] disp;
    logic        absMode, toLr, link, mode64, vlSet, vsb, vlInc, allMode, lrU;
    logic [6:0]  src;
    logic        endIn;
  } stim_t;

  typedef struct packed {
    logic        valid, taken, lrw, vlw, el;
    logic [63:0] next, lrv, ctr;
    logic [6:0]  vlv;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, inValid = 1'b0;
  stim_t s = '0;
  exp_t  e = '0;
  int checks = 0, errors = 0;

  logic outValid, branchTaken, lrWrEn, vlWrEn, endLoop;
  logic [63:0] nextAddr, lrValue, ctrNext;
  logic [6:0] vlValue;

  always #5 clk = ~clk;

  vec_branch_step i_vec_branch_step (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opts(s.opts),
    .condBit(s.condBit), .snz(s.snz), .zeroing(s.zeroing), .ctrIn(s.ctr),
    .cia(s.cia), .disp(s.disp), .lrIn(s.lr), .absMode(s.absMode),
    .toLr(s.toLr), .link(s.link), .mode64(s.mode64), .vlSet(s.vlSet),
    .vsb(s.vsb), .vlInc(s.vlInc), .allMode(s.allMode), .lrU(s.lrU),
    .srcStep(s.src), .endLoopIn(s.endIn), .outValid(outValid),
    .branchTaken(branchTaken), .nextAddr(nextAddr), .lrWrEn(lrWrEn),
    .lrValue(lrValue), .ctrNext(ctrNext), .vlWrEn(vlWrEn),
    .vlValue(vlValue), .endLoop(endLoop)
  );

  task automatic chk(input string tag, input string name, input logic [63:0] act, input logic [63:0] exv);
    checks++;
    if (act !== exv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, name, act, exv);
    end
  endtask

  task automatic compareAll();
    chk("R11", "outValid", {63'd0, outValid}, {63'd0, e.valid});
    chk("R1", "ctrNext", ctrNext, e.ctr);
    chk("R6 R2 R3", "branchTaken", {63'd0, branchTaken}, {63'd0, e.taken});
    chk("R7 R8 R10", "nextAddr", nextAddr, e.next);
    chk("R9", "lrWrEn", {63'd0, lrWrEn}, {63'd0, e.lrw});
    chk("R9 R8", "lrValue", lrValue, e.lrv);
    chk("R4 R10", "vlWrEn", {63'd0, vlWrEn}, {63'd0, e.vlw});
    chk("R4", "vlValue", {57'd0, vlValue}, {57'd0, e.vlv});
    chk("R5 R6", "endLoop", {63'd0, endLoop}, {63'd0, e.el});
  endtask

  // Behavioural model of one step, written from the requirements.
  function automatic exp_t model(input stim_t t, input bit v, input exp_t prev);
    exp_t r;
    logic [63:0] c, tgt, msk;
    bit nz, ctrOk, condOk, ok, tb, tryB, tk, el, vw;
    r = prev;
    r.valid = v; r.taken = 1'b0; r.lrw = 1'b0; r.vlw = 1'b0;
    if (!v) return r;
    c = t.opts[2] ? t.ctr : t.ctr - 64'd1;
    nz = t.mode64 ? (c != 0) : (c[31:0] != 0);
    ctrOk = t.opts[2] || (nz != t.opts[1]);
    tb = t.zeroing ? t.snz : t.condBit;
    condOk = t.opts[4] || (tb == t.opts[3]);
    ok = ctrOk && condOk;
    el = t.endIn; vw = 1'b0; tryB = 1'b1;
    if (t.toLr) begin
      tgt = {t.lr[63:2], 2'b00};
    end else begin
      if (t.vlSet && (ok == t.vsb)) begin vw = 1'b1; el = 1'b1; end
      if (t.allMode) begin
        if (!el) tryB = 1'b0;
        if (!ok) begin el = 1'b1; tryB = 1'b0; end
      end
      tgt = {{48{t.disp[13]}}, t.disp, 2'b00};
      if (!t.absMode) tgt = tgt + t.cia;
    end
    tk = tryB && ok;
    if (tk && !t.toLr) el = 1'b1;
    msk = t.mode64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    r.ctr = c;
    r.taken = tk;
    r.next = (tk ? tgt : t.cia + 64'd4) & msk;
    r.lrv = (t.cia + 64'd4) & msk;
    r.lrw = t.link && (t.lrU || tk);
    r.vlw = vw;
    r.vlv = t.vlInc ? t.src + 7'd1 : t.src;
    r.el = el;
    return r;
  endfunction

  // Compare the previous step's results, then apply a new step.
  task automatic step(input stim_t t, input bit v);
    @(negedge clk);
    compareAll();
    s = t;
    inValid = v;
    e = model(t, v, e);
  endtask

  function automatic stim_t randStim();
    stim_t t;
    int k;
    t = '0;
    t.opts = 5'($urandom);
    {t.condBit, t.snz, t.zeroing, t.absMode, t.link, t.mode64, t.vlSet, t.vsb} = 8'($urandom);
    {t.vlInc, t.allMode, t.lrU, t.endIn} = 4'($urandom);
    t.toLr = ($urandom % 5) == 0;
    k = $urandom % 6;
    case (k)
      0: t.ctr = 64'd0;
      1: t.ctr = 64'd1;
      2: t.ctr = 64'd2;
      3: t.ctr = 64'h0000_0001_0000_0001;
      default: t.ctr = {$urandom, $urandom};
    endcase
    t.cia = {$urandom, $urandom};
    t.lr = {$urandom, $urandom};
    t.disp = 14'($urandom);
    t.src = 7'($urandom);
    return t;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    stim_t t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state observed on the first compare
    step('0, 1'b0);

    // R1 R2: decrement to zero, branch when zero (opts bit3=1 -> opts[1])
    t = '0; t.opts = 5'b10010; t.ctr = 64'd1; t.cia = 64'h1000; t.disp = 14'h3FFF; t.mode64 = 1'b1;
    step(t, 1'b1);
    // R11: idle cycle, strobes drop, data held
    step(t, 1'b0);
    // R2 R8: 32-bit mode, low word reaches zero while upper bits nonzero
    t.ctr = 64'h0000_0001_0000_0001; t.mode64 = 1'b0; t.cia = 64'hABCD_0000_0000_1000;
    step(t, 1'b1);
    t.mode64 = 1'b1;
    step(t, 1'b1);
    // R3: zeroing substitutes snz; condition must be 1
    t = '0; t.opts = 5'b01100; t.zeroing = 1'b1; t.snz = 1'b1; t.condBit = 1'b0; t.mode64 = 1'b1; t.cia = 64'h200;
    t.disp = 14'h0010; t.absMode = 1'b1;
    step(t, 1'b1);
    t.snz = 1'b0; t.condBit = 1'b1;
    step(t, 1'b1);
    // R4 R5: ALL mode, VL trigger ends loop, branch then allowed
    t = '0; t.opts = 5'b10100; t.mode64 = 1'b1; t.allMode = 1'b1; t.vlSet = 1'b1; t.vsb = 1'b1;
    t.vlInc = 1'b1; t.src = 7'd127; t.cia = 64'h4000; t.disp = 14'h0004;
    step(t, 1'b1);
    // R5: ALL mode, tests pass but loop not ending -> no branch
    t.vlSet = 1'b0;
    step(t, 1'b1);
    // R5: ALL mode, test fails -> early exit
    t.opts = 5'b00100; t.condBit = 1'b1;
    step(t, 1'b1);
    // R9: link update without a taken branch under lrU
    t = '0; t.opts = 5'b00100; t.condBit = 1'b1; t.link = 1'b1; t.lrU = 1'b1; t.mode64 = 1'b1; t.cia = 64'h8;
    step(t, 1'b1);
    t.lrU = 1'b0;
    step(t, 1'b1);
    // R10: link-register variant ignores vector controls
    t = '0; t.toLr = 1'b1; t.opts = 5'b10100; t.lr = 64'hFFFF_0000_1234_567B; t.mode64 = 1'b1;
    t.vlSet = 1'b1; t.vsb = 1'b1; t.allMode = 1'b1; t.link = 1'b1;
    step(t, 1'b1);
    t.mode64 = 1'b0;
    step(t, 1'b1);

    for (int i = 0; i < 4000; i++) step(randStim(), ($urandom % 5) != 0);
    step('0, 1'b0);
    step('0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule